// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Multiplier

This block multiplies two 64-bit source operands over a fixed number of cycles and returns a 64-bit result. An operation code picks the result. It can be the full product of the low 32-bit halves of the sources. It can be the upper half of that word product, copied into both halves of the result. It can be the lower or the upper 64 bits of the full 128-bit product. It can also be a multiply-add in which a third operand is added to the 128-bit product before a half is taken. Signed forms treat the operands as two's complement, and unsigned forms treat them as plain binary. The two low-product forms also report an overflow flag. The flag is set when the upper bits that are thrown away are more than a sign extension of the bits that are kept.

A request is a one-cycle `start_i` pulse. Operands and code are sampled on the clock edge that accepts the pulse. The block uses a radix-2 shift-add loop on operand magnitudes, so the sources may change after acceptance. `done_o` pulses for one cycle when the result is ready. `result_o` and `ovf_o` then keep their values until the next completion. A start that arrives while a request is in flight is dropped.

Bit positions below use LSB-0 numbering: bit 63 is the most significant bit of a 64-bit value.

Top module: `imul_unit`

## Requirements
- R1: The word forms (codes 0, 1, 2) use only bits 31:0 of `ra_i` and `rb_i`. Bits 63:32 of both sources have no effect on their result or overflow.
- R2: Code 0 returns the full 64-bit signed product of the two sign-extended low words.
- R3: Code 1 (signed) and code 2 (unsigned) form the 64-bit product of the low words. Its bits 63:32 appear in both result bits 63:32 and result bits 31:0.
- R4: For code 0, `ovf_o` is 1 exactly when bits 63:31 of the 64-bit product are neither all zeros nor all ones.
- R5: Code 3 returns bits 63:0 of the signed 128-bit product. `ovf_o` is 1 exactly when product bits 127:63 are neither all zeros nor all ones.
- R6: Code 4 returns bits 127:64 of the signed 128-bit product. Code 5 returns bits 127:64 of the unsigned 128-bit product.
- R7: Multiply-add forms return a half of the 128-bit product plus `rc_i`. Code 6 returns bits 127:64 of signed product plus sign-extended `rc_i`. Code 7 returns bits 63:0 of signed product plus sign-extended `rc_i`. Code 8 returns bits 127:64 of unsigned product plus zero-extended `rc_i`.
- R8: `ovf_o` is 0 after every operation other than codes 0 and 3.
- R9: `done_o` is high for exactly one cycle. It is high in the cycle that follows the W+1-th rising edge after the edge that accepted `start_i` (65 edges for W=64).
- R10: `result_o` and `ovf_o` change only at completion. They hold their values while `done_o` is low.
- R11: A `start_i` that arrives while a request is in flight is ignored. The request in flight completes with its own operands and code, at its own time.
- R12: During and after synchronous active-low reset, `done_o`, `ovf_o` and `result_o` are 0 until the first completion.
- R13: Codes 9 to 15 complete normally with `result_o` = 0 and `ovf_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted when idle |
| op_i | input | 4 | Operation code (0 to 8 defined) |
| ra_i | input | 64 | First multiplicand |
| rb_i | input | 64 | Second multiplicand |
| rc_i | input | 64 | Addend for multiply-add codes |
| result_o | output | 64 | Selected result, held between completions |
| ovf_o | output | 1 | Low-product overflow, held with the result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker derives acceptance from `start_i` and the internal busy state. It assumes `start_i` and `op_i` are stable at each rising edge and that reset is held for at least one edge. Under those assumptions it checks the completion latency, the pulse shape, result holding, dropped starts and the overflow and duplication rules for the code captured at acceptance. The bench changes every input only on falling edges and drops `start_i` after the accepting edge, except in the dropped-start test. That test holds `start_i` high on purpose across the busy window and releases it before completion. Bits 63:32 of the sources are filled with unrelated values on word-form requests, so the low-word selection is exercised.

// File: rtl/imul_pkg.sv
// Package: operation codes shared by the multiplier and its checker.
// Assumes a 4-bit operation select; codes above OP_MADD_HU are unused.
package imul_pkg;
    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_MUL_LW  = 4'd0,  // signed word, full 64-bit product
        OP_MUL_HWS = 4'd1,  // signed word, high half duplicated
        OP_MUL_HWU = 4'd2,  // unsigned word, high half duplicated
        OP_MUL_LD  = 4'd3,  // signed doubleword, low 64 bits
        OP_MUL_HDS = 4'd4,  // signed doubleword, high 64 bits
        OP_MUL_HDU = 4'd5,  // unsigned doubleword, high 64 bits
        OP_MADD_HS = 4'd6,  // signed product + sext addend, high
        OP_MADD_L  = 4'd7,  // signed product + sext addend, low
        OP_MADD_HU = 4'd8   // unsigned product + zext addend, high
    } op_e;
endpackage

// File: rtl/imul_opnd.sv
// Operand preparation: selects word or full-width sources, applies sign or
// zero extension, produces unsigned magnitudes for the shift-add core, the
// sign of the final product, and the extended addend.
// Assumes W is even; purely combinational.
module imul_opnd
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [OP_BITS-1:0] op_i,
    input  logic [W-1:0]       ra_i,
    input  logic [W-1:0]       rb_i,
    input  logic [W-1:0]       rc_i,
    output logic [W-1:0]       mag_a_o,
    output logic [W-1:0]       mag_b_o,
    output logic               neg_o,
    output logic [2*W-1:0]     addend_o
);
    localparam int HW = W / 2;

    logic           is_signed;
    logic           is_word;
    logic [W-1:0]   a_ext;
    logic [W-1:0]   b_ext;
    logic           a_neg;
    logic           b_neg;

    // Decode signedness and word/full width from the operation code.
    always_comb begin
        is_signed = !(op_i == OP_MUL_HWU || op_i == OP_MUL_HDU || op_i == OP_MADD_HU);
        is_word   = (op_i == OP_MUL_LW || op_i == OP_MUL_HWS || op_i == OP_MUL_HWU);
    end

    // Extend sources to full width and convert to magnitudes.
    always_comb begin
        a_ext   = is_word ? {{HW{is_signed & ra_i[HW-1]}}, ra_i[HW-1:0]} : ra_i;
        b_ext   = is_word ? {{HW{is_signed & rb_i[HW-1]}}, rb_i[HW-1:0]} : rb_i;
        a_neg   = is_signed & a_ext[W-1];
        b_neg   = is_signed & b_ext[W-1];
        mag_a_o = a_neg ? (~a_ext + 1'b1) : a_ext;
        mag_b_o = b_neg ? (~b_ext + 1'b1) : b_ext;
        neg_o   = a_neg ^ b_neg;
    end

    // Extend the addend for the multiply-add codes; zero otherwise.
    always_comb begin
        unique case (op_i)
            OP_MADD_HS, OP_MADD_L: addend_o = {{W{rc_i[W-1]}}, rc_i};
            OP_MADD_HU:            addend_o = {{W{1'b0}}, rc_i};
            default:               addend_o = '0;
        endcase
    end
endmodule

// File: rtl/imul_core.sv
// Radix-2 shift-add multiplier of two unsigned W-bit magnitudes.
// A load starts W add/shift steps; fin_o pulses one cycle after the last step
// while prod_o holds the 2W-bit product. Assumes load_i only when !busy_o.
module imul_core #(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           fin_o,
    output logic [2*W-1:0] prod_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  mc_q;
    logic [W-1:0]  hi_q;
    logic [W-1:0]  lo_q;
    logic [CW-1:0] step_q;
    logic          run_q;
    logic          fin_q;
    logic [W:0]    psum;

    // Partial sum of the high accumulator and the gated multiplicand.
    always_comb begin
        psum = {1'b0, hi_q} + {1'b0, (lo_q[0] ? mc_q : {W{1'b0}})};
    end

    // Step sequencer: load operands, then add and shift once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q   <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load_i) begin
                mc_q   <= mcand_i;
                hi_q   <= '0;
                lo_q   <= mplier_i;
                step_q <= '0;
                run_q  <= 1'b1;
            end else if (run_q) begin
                hi_q   <= psum[W:1];
                lo_q   <= {psum[0], lo_q[W-1:1]};
                step_q <= step_q + 1'b1;
                if (step_q == CW'(W - 1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = run_q | fin_q;
    assign fin_o  = fin_q;
    assign prod_o = {hi_q, lo_q};
endmodule

// File: rtl/imul_fmt.sv
// Result formatting: restores the product sign, adds the extended addend,
// selects the result half for the code and judges low-product overflow.
// Assumes prod_i is an unsigned magnitude product; purely combinational.
module imul_fmt
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [OP_BITS-1:0] op_i,
    input  logic [2*W-1:0]     prod_i,
    input  logic               neg_i,
    input  logic [2*W-1:0]     addend_i,
    output logic [W-1:0]       res_o,
    output logic               ovf_o
);
    localparam int HW = W / 2;

    logic [2*W-1:0] sprod;
    logic [2*W-1:0] total;
    logic [HW:0]    word_top;
    logic [W:0]     dbl_top;

    // Apply sign and addend to the magnitude product.
    always_comb begin
        sprod    = neg_i ? (~prod_i + 1'b1) : prod_i;
        total    = sprod + addend_i;
        word_top = total[W-1:HW-1];
        dbl_top  = total[2*W-1:W-1];
    end

    // Pick the result half and the overflow judgement for the code.
    always_comb begin
        res_o = '0;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_MUL_LW: begin
                res_o = total[W-1:0];
                ovf_o = !((&word_top) | ~(|word_top));
            end
            OP_MUL_HWS, OP_MUL_HWU: res_o = {total[W-1:HW], total[W-1:HW]};
            OP_MUL_LD: begin
                res_o = total[W-1:0];
                ovf_o = !((&dbl_top) | ~(|dbl_top));
            end
            OP_MUL_HDS, OP_MUL_HDU, OP_MADD_HS, OP_MADD_HU: res_o = total[2*W-1:W];
            OP_MADD_L: res_o = total[W-1:0];
            default: begin
                res_o = '0;
                ovf_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/imul_unit.sv
// Multicycle signed/unsigned multiplier with multiply-add. Accepts start_i
// when idle, captures the code, sign and addend, runs the shift-add core and
// registers the formatted result with a one-cycle done pulse.
// Assumes start_i is a level sampled at rising edges; starts while busy drop.
module imul_unit
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [OP_BITS-1:0] op_i,
    input  logic [W-1:0]       ra_i,
    input  logic [W-1:0]       rb_i,
    input  logic [W-1:0]       rc_i,
    output logic [W-1:0]       result_o,
    output logic               ovf_o,
    output logic               done_o
);
    logic [W-1:0]       mag_a;
    logic [W-1:0]       mag_b;
    logic               neg_d;
    logic [2*W-1:0]     addend_d;
    logic               core_busy;
    logic               core_fin;
    logic [2*W-1:0]     core_prod;
    logic               accept;
    logic [OP_BITS-1:0] op_q;
    logic               neg_q;
    logic [2*W-1:0]     addend_q;
    logic [W-1:0]       fmt_res;
    logic               fmt_ovf;
    logic [W-1:0]       result_q;
    logic               ovf_q;
    logic               done_q;

    imul_opnd #(.W(W)) u_opnd (
        .op_i     (op_i),
        .ra_i     (ra_i),
        .rb_i     (rb_i),
        .rc_i     (rc_i),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .neg_o    (neg_d),
        .addend_o (addend_d)
    );

    // A request is taken only while the core is idle.
    assign accept = start_i & ~core_busy;

    imul_core #(.W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .mcand_i  (mag_a),
        .mplier_i (mag_b),
        .busy_o   (core_busy),
        .fin_o    (core_fin),
        .prod_o   (core_prod)
    );

    // Capture the per-request controls at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            neg_q    <= 1'b0;
            addend_q <= '0;
        end else if (accept) begin
            op_q     <= op_i;
            neg_q    <= neg_d;
            addend_q <= addend_d;
        end
    end

    imul_fmt #(.W(W)) u_fmt (
        .op_i     (op_q),
        .prod_i   (core_prod),
        .neg_i    (neg_q),
        .addend_i (addend_q),
        .res_o    (fmt_res),
        .ovf_o    (fmt_ovf)
    );

    // Register the result at completion and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            ovf_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= core_fin;
            if (core_fin) begin
                result_q <= fmt_res;
                ovf_q    <= fmt_ovf;
            end
        end
    end

    assign result_o = result_q;
    assign ovf_o    = ovf_q;
    assign done_o   = done_q;
endmodule

// File: rtl/imul_chk.sv
// Checker for imul_unit: tracks each accepted request and its code, then
// checks latency, pulse shape, holding, dropped starts and result rules.
// Assumes inputs are stable at rising edges.
module imul_chk
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [OP_BITS-1:0] op_i,
    input logic               busy_i,
    input logic [OP_BITS-1:0] op_q_i,
    input logic [W-1:0]       result_o,
    input logic               ovf_o,
    input logic               done_o
);
    localparam int HW    = W / 2;
    localparam int CNT_W = $clog2(W + 4) + 1;

    logic [CNT_W-1:0]   cnt;
    logic               fly;
    logic [OP_BITS-1:0] op_c;

    // Count cycles since the accepting edge and remember the code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fly  <= 1'b0;
            op_c <= '0;
        end else if (start_i && !busy_i) begin
            cnt  <= CNT_W'(1);
            fly  <= 1'b1;
            op_c <= op_i;
        end else if (fly) begin
            cnt <= cnt + 1'b1;
            if (done_o) fly <= 1'b0;
        end
    end

    // R9: done appears only at the fixed latency after acceptance.
    p_done_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fly && cnt == CNT_W'(W + 2)));

    // R9: done lasts a single cycle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: outputs hold while no completion is signalled.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovf_o)));

    // R11: a start while busy leaves the captured code alone.
    p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && start_i) |=> $stable(op_q_i));

    // R8: overflow only for the two low-product codes.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_c != OP_MUL_LW && op_c != OP_MUL_LD) |-> !ovf_o);

    // R3: high-word forms give two equal halves.
    p_dup_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_c == OP_MUL_HWS || op_c == OP_MUL_HWU))
            |-> (result_o[W-1:HW] == result_o[HW-1:0]));
endmodule

bind imul_unit imul_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .busy_i   (core_busy),
    .op_q_i   (op_q),
    .result_o (result_o),
    .ovf_o    (ovf_o),
    .done_o   (done_o)
);

// File: tb/imul_unit_tb.sv
// Bench for imul_unit: a vector table checked against an independent
// 128-bit reference model, then directed reset and corner-case tests.
module imul_unit_tb_top;
    localparam int W  = 64;
    localparam int NV = 16;
    localparam int LAT = W + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    op_i = '0;
    logic [W-1:0]  ra_i = '0;
    logic [W-1:0]  rb_i = '0;
    logic [W-1:0]  rc_i = '0;
    logic [W-1:0]  result_o;
    logic          ovf_o;
    logic          done_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;  // 250 MHz

    imul_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i),
        .result_o(result_o), .ovf_o(ovf_o), .done_o(done_o)
    );

    localparam logic [3:0] T_OP [NV] = '{
        4'd0, 4'd0, 4'd0, 4'd1, 4'd2, 4'd1, 4'd3, 4'd3,
        4'd3, 4'd4, 4'd5, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};
    localparam logic [63:0] T_A [NV] = '{
        64'd7, 64'hDEAD_BEEF_FFFF_FFFD, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF,
        64'hFFFF_FFFF, 64'h1234_5678, 64'h4000_0000_0000_0000, -64'sd5,
        64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, '1, -64'sd3,
        -64'sd1, 64'd123456789, '1, 64'd5};
    localparam logic [63:0] T_B [NV] = '{
        64'd6, 64'h0000_0001_0000_0005, 64'd2, 64'h5555_AAAA_8000_0000,
        64'h8000_0000, 64'h9ABC_DEF0, 64'd2, -64'sd7,
        '1, 64'h8000_0000_0000_0000, '1, 64'h0123_4567_89AB_CDEF,
        64'd1, 64'd987654321, '1, 64'd5};
    localparam logic [63:0] T_C [NV] = '{
        64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
        64'd0, 64'd0, 64'd0, 64'd0, -64'sd1, -64'sd100, '1, 64'd0};

    // Reference: build the 128-bit product from extended operands.
    function automatic void model(input logic [3:0] op, input logic [63:0] a, b, c,
                                  output logic [63:0] r, output logic o);
        logic [127:0] xa, xb, xc, p;
        xc = '0;
        case (op)
            4'd0, 4'd1: begin xa = {{96{a[31]}}, a[31:0]}; xb = {{96{b[31]}}, b[31:0]}; end
            4'd2:       begin xa = {96'd0, a[31:0]};       xb = {96'd0, b[31:0]};       end
            4'd5, 4'd8: begin xa = {64'd0, a};             xb = {64'd0, b};             end
            default:    begin xa = {{64{a[63]}}, a};       xb = {{64{b[63]}}, b};       end
        endcase
        if (op == 4'd6 || op == 4'd7) xc = {{64{c[63]}}, c};
        if (op == 4'd8) xc = {64'd0, c};
        p = xa * xb + xc;
        o = 1'b0;
        case (op)
            4'd0: begin r = p[63:0]; o = !((&p[63:31]) | ~(|p[63:31])); end
            4'd1, 4'd2: r = {p[63:32], p[63:32]};
            4'd3: begin r = p[63:0]; o = !((&p[127:63]) | ~(|p[127:63])); end
            4'd4, 4'd5, 4'd6, 4'd8: r = p[127:64];
            4'd7: r = p[63:0];
            default: r = '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R2";
            4'd1, 4'd2: return "R3";
            4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            4'd6, 4'd7, 4'd8: return "R7";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for done; n counts edges after acceptance.
    task automatic run(input logic [3:0] op, input logic [63:0] a, b, c,
                       output logic [63:0] r, output logic o, output int n);
        @(negedge clk);
        op_i = op; ra_i = a; rb_i = b; rc_i = c; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        ra_i = '1; rb_i = '1; rc_i = '1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!done_o && n < 300);
        r = result_o;
        o = ovf_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] r, er, held;
        logic        o, eo;
        int          n;

        // R12: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 done", {63'd0, done_o}, 64'd0);
        chk("R12 result", result_o, 64'd0);
        chk("R12 ovf", {63'd0, ovf_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 result after release", result_o, 64'd0);

        // Table walk against the reference model; latency checked on each.
        for (int i = 0; i < NV; i++) begin
            run(T_OP[i], T_A[i], T_B[i], T_C[i], r, o, n);
            model(T_OP[i], T_A[i], T_B[i], T_C[i], er, eo);
            chk(tag_of(T_OP[i]), r, er);
            chk({tag_of(T_OP[i]), " ovf R8"}, {63'd0, o}, {63'd0, eo});
            chk("R9 latency", 64'(n), 64'(LAT));
        end

        // R1 / R2: junk upper bits ignored, -3 * 5.
        run(4'd0, 64'h0BAD_F00D_FFFF_FFFD, 64'h7777_0000_0000_0005, 64'd0, r, o, n);
        chk("R1 R2 low word", r, 64'hFFFF_FFFF_FFFF_FFF1);
        chk("R1 ovf", {63'd0, o}, 64'd0);

        // R3: unsigned high word of all-ones squared.
        run(4'd2, 64'h1234_0000_FFFF_FFFF, 64'hFFFF_FFFF, 64'd0, r, o, n);
        chk("R3 high word dup", r, 64'hFFFF_FFFE_FFFF_FFFE);

        // R4: overflow boundary for the word form.
        run(4'd0, 64'h7FFF_FFFF, 64'd2, 64'd0, r, o, n);
        chk("R4 value", r, 64'h0000_0000_FFFF_FFFE);
        chk("R4 ovf set", {63'd0, o}, 64'd1);
        run(4'd0, 64'h4000_0000, 64'hFFFF_FFFE, 64'd0, r, o, n);
        chk("R4 value neg", r, 64'hFFFF_FFFF_8000_0000);
        chk("R4 ovf clear", {63'd0, o}, 64'd0);

        // R5: doubleword overflow boundary.
        run(4'd3, 64'h4000_0000_0000_0000, 64'd2, 64'd0, r, o, n);
        chk("R5 value", r, 64'h8000_0000_0000_0000);
        chk("R5 ovf set", {63'd0, o}, 64'd1);
        run(4'd3, 64'h8000_0000_0000_0000, 64'd1, 64'd0, r, o, n);
        chk("R5 ovf clear", {63'd0, o}, 64'd0);

        // R6: unsigned high of all-ones squared.
        run(4'd5, '1, '1, 64'd0, r, o, n);
        chk("R6 unsigned high", r, 64'hFFFF_FFFF_FFFF_FFFE);

        // R7: carry into the high half and a low result wrapping to zero.
        run(4'd8, '1, 64'd2, 64'd2, r, o, n);
        chk("R7 zext addend carry", r, 64'd2);
        run(4'd7, '1, 64'd1, 64'd1, r, o, n);
        chk("R7 low madd", r, 64'd0);

        // R13: unused code yields zero.
        run(4'd11, 64'd9, 64'd9, 64'd9, r, o, n);
        chk("R13 result", r, 64'd0);
        chk("R13 ovf", {63'd0, o}, 64'd0);

        // R10: hold after done while inputs change.
        run(4'd0, 64'd3, 64'd5, 64'd0, r, o, n);
        held = r;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            op_i = 4'(k); ra_i = 64'(k * 77); rb_i = 64'(k + 1);
        end
        chk("R10 result held", result_o, held);
        chk("R9 done low after pulse", {63'd0, done_o}, 64'd0);

        // R11: start held high while busy is dropped.
        @(negedge clk);
        op_i = 4'd0; ra_i = 64'd3; rb_i = 64'd4; rc_i = '0; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_i = 4'd3; ra_i = 64'h4000_0000_0000_0000; rb_i = 64'd8;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 20) start_i = 1'b0;
        end while (!done_o && n < 300);
        chk("R11 result of first request", result_o, 64'd12);
        chk("R11 ovf of first request", {63'd0, ovf_o}, 64'd0);
        chk("R11 latency unchanged", 64'(n), 64'(LAT));
        repeat (LAT + 3) @(negedge clk);
        chk("R11 no second completion", result_o, 64'd12);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule